// File: doc/BRIEF.md
# Match Channel Array with Grouped Counters

This block provides eight match channels, numbered 4 to 11, for a timer subsystem. Every channel has a counter, a match value and a control word. A channel's counter advances on the cycles where the tick-enable input chosen by its clock selection is high. A channel compares either against its own counter or against the counter of the channel that leads its group. The groups are channels 4 to 7 (led by 4), channels 8 and 9 (led by 8), and channels 10 and 11 (led by 10). A match can clear the channel's own counter. It can also re-arm the channel or leave it idle until software arms it again.

Each match on an enabled channel sets a status bit at position 4 to 11. All of these bits feed one interrupt line, and software clears them by writing ones. Channels 9 and 11 can take a snapshot: when software reads their counter, the counter of the channel just below them is copied into a snapshot register. Software reaches everything through a simple word-addressed read/write port. Writes take effect at the clock edge, and read data is registered.

Top module: `mca_array`

## Requirements
- R1: After reset every counter, match value, control word, clock selection, the enable word, the status word, the snapshot and rd_data are zero, and irq is low.
- R2: A channel's counter increments by one at each clock edge where tick_en[sel] is high, sel being its stored 3-bit clock selection. A selection of 0 never advances the counter, and ticks on other tick_en bits have no effect.
- R3: With control bit 7 clear, a channel compares against its group leader's counter (4 for 4..7, 8 for 8..9, 10 for 10..11). With bit 7 set, it compares against its own counter.
- R4: A match happens when an armed channel's compared counter advances onto the match value. The match sets status bit 4+n (n = channel minus 4) at that same edge, and only if enable bit 4+n is set.
- R5: With control bit 3 set, a match loads the channel's own counter with 0 instead of letting it advance.
- R6: Writing the match value or the control word arms a channel. A match disarms it unless control bit 6 is set, in which case it stays armed and matches again.
- R7: A control write stores bits [7:0] for channels 4..7 and bits [9:0] for channels 8..11, and reads back the same.
- R8: A control write updates the clock selection from bits [2:0] only when bit 7 of the written value is set or the channel leads its group. Otherwise the previous selection is kept.
- R9: For channels 8..11, a control write with bit 8 set makes the selection 0, which stops the counter.
- R10: Reading the counter of channel 9 or 11 while its control bit 9 is set copies the counter of channel 8 or 10 into the snapshot register. The snapshot keeps its value through every other read or write.
- R11: irq is high while any status bit is set. Writing the status word clears each bit whose written bit is 1. irq falls only when the last set bit is cleared.
- R12: Register map (5-bit word address): match values 0..7, counters 8..15, control words 16..23 (index = channel minus 4), status 24 (bits 11:4), enable 24+1 (bits 11:4), snapshot 24+2. rd_data shows the addressed register one clock after rd_en and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 8 | One tick enable per clock-selection code; bit 0 is unused |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Combined interrupt for status bits 4..11 |

## Verification
Counter, match-value, control, enable and status writes all take effect at the edge that samples wr_en. A match changes the counter and sets the status bit at the edge of the tick that reaches the match value. irq follows the status bits with no further register. The snapshot is captured at the edge that samples rd_en, and rd_data appears at that same edge. The bench drives each stimulus on the falling edge and holds it for a whole number of cycles. It reads results back through the read port one edge later, or samples irq on the falling edge after the edge that should change it, so every comparison falls half a cycle after the result is due.

// File: rtl/mca_pkg.sv
package mca_pkg;
   localparam int DW        = 32;
   localparam int NCH       = 8;
   localparam int NSRC      = 8;
   localparam int SEL_W     = $clog2(NSRC);
   localparam int AW        = 5;
   localparam int CTRL_FULL = 10;
   localparam int ST_OFS    = 4;

   // control bit positions
   localparam int CB_RST   = 3;
   localparam int CB_PER   = 6;
   localparam int CB_OWN   = 7;
   localparam int CB_FORCE = 8;
   localparam int CB_SNAP  = 9;

   typedef enum logic [1:0] {
      RG_MATCH = 2'b00,
      RG_COUNT = 2'b01,
      RG_CTRL  = 2'b10,
      RG_MISC  = 2'b11
   } region_e;

   localparam logic [2:0] MX_STATUS = 3'd0;
   localparam logic [2:0] MX_ENABLE = 3'd1;
   localparam logic [2:0] MX_SNAP   = 3'd2;

   function automatic int lead_of(input int k);
      if (k < 4)      return 0;
      else if (k < 6) return 4;
      else            return 6;
   endfunction

   function automatic int ctrl_w_of(input int k);
      return (k < 4) ? 8 : 10;
   endfunction
endpackage

// File: rtl/mca_channel.sv
module mca_channel import mca_pkg::*; #(
   parameter int CNT_W   = 32,
   parameter int CTRL_W  = 8,
   parameter bit IS_LEAD = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NSRC-1:0]      tick_en,
   input  logic                 wr_match,
   input  logic                 wr_cnt,
   input  logic                 wr_ctrl,
   input  logic [DW-1:0]        wdata,
   input  logic [CNT_W-1:0]     lead_cnt,
   input  logic                 lead_adv,
   output logic [CNT_W-1:0]     cnt_o,
   output logic                 adv_o,
   output logic [CTRL_FULL-1:0] ctrl_o,
   output logic [CNT_W-1:0]     match_o,
   output logic [SEL_W-1:0]     sel_o,
   output logic                 hit_o
);
   localparam bit HAS_FORCE = CTRL_W > CB_FORCE;

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  cnt_q, match_q, src_cnt;
   logic [SEL_W-1:0]  sel_q, sel_nxt;
   logic              armed_q, src_adv, force_off;

   generate
      if (HAS_FORCE) begin : g_force
         assign force_off = wdata[CB_FORCE];
      end else begin : g_noforce
         assign force_off = 1'b0;
      end
   endgenerate

   assign sel_nxt = force_off ? '0 : wdata[SEL_W-1:0];
   assign adv_o   = (sel_q != '0) && tick_en[sel_q];
   assign src_cnt = ctrl_q[CB_OWN] ? cnt_q : lead_cnt;
   assign src_adv = ctrl_q[CB_OWN] ? adv_o : lead_adv;
   assign hit_o   = armed_q && src_adv && ((src_cnt + CNT_W'(1)) == match_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         sel_q   <= '0;
         cnt_q   <= '0;
         match_q <= '0;
         armed_q <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_q <= wdata[CTRL_W-1:0];
            if (wdata[CB_OWN] || IS_LEAD) sel_q <= sel_nxt;
         end
         if (wr_match) match_q <= wdata[CNT_W-1:0];
         if (wr_cnt)                        cnt_q <= wdata[CNT_W-1:0];
         else if (hit_o && ctrl_q[CB_RST])  cnt_q <= '0;
         else if (adv_o)                    cnt_q <= cnt_q + CNT_W'(1);
         if (wr_match || wr_ctrl)           armed_q <= 1'b1;
         else if (hit_o && !ctrl_q[CB_PER]) armed_q <= 1'b0;
      end
   end

   assign cnt_o   = cnt_q;
   assign match_o = match_q;
   assign sel_o   = sel_q;
   assign ctrl_o  = CTRL_FULL'(ctrl_q);
endmodule

// File: rtl/mca_irq.sv
module mca_irq import mca_pkg::*; #(
   parameter int N = NCH
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] hit,
   input  logic         wr_enable,
   input  logic         wr_status,
   input  logic [N-1:0] wbits,
   output logic [N-1:0] en_o,
   output logic [N-1:0] stat_o,
   output logic         irq
);
   logic [N-1:0] en_q, stat_q, clr;

   assign clr = wr_status ? wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         stat_q <= '0;
      end else begin
         if (wr_enable) en_q <= wbits;
         stat_q <= (stat_q & ~clr) | (hit & en_q);
      end
   end

   assign en_o   = en_q;
   assign stat_o = stat_q;
   assign irq    = |stat_q;
endmodule

// File: rtl/mca_array.sv
module mca_array import mca_pkg::*; #(
   parameter int CNT_W = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [7:0]    tick_en,
   input  logic          wr_en,
   input  logic [4:0]    wr_addr,
   input  logic [31:0]   wr_data,
   input  logic          rd_en,
   input  logic [4:0]    rd_addr,
   output logic [31:0]   rd_data,
   output logic          irq
);
   generate
      if (CNT_W < 8 || CNT_W > DW) begin : g_bad_cnt_w
         $error("mca_array: CNT_W must lie in 8..32");
      end
      if (NSRC != 8 || AW != 5) begin : g_bad_map
         $error("mca_array: port widths assume 8 sources and 5 address bits");
      end
   endgenerate

   region_e wr_rg, rd_rg;
   logic [2:0] wr_k, rd_k;
   assign wr_rg = region_e'(wr_addr[4:3]);
   assign rd_rg = region_e'(rd_addr[4:3]);
   assign wr_k  = wr_addr[2:0];
   assign rd_k  = rd_addr[2:0];

   logic [NCH-1:0] wr_m, wr_c, wr_t;
   logic           wr_stat, wr_enab;

   always_comb begin
      for (int k = 0; k < NCH; k++) begin
         wr_m[k] = wr_en && (wr_rg == RG_MATCH) && (wr_k == 3'(k));
         wr_c[k] = wr_en && (wr_rg == RG_COUNT) && (wr_k == 3'(k));
         wr_t[k] = wr_en && (wr_rg == RG_CTRL)  && (wr_k == 3'(k));
      end
   end
   assign wr_stat = wr_en && (wr_rg == RG_MISC) && (wr_k == MX_STATUS);
   assign wr_enab = wr_en && (wr_rg == RG_MISC) && (wr_k == MX_ENABLE);

   logic [NCH-1:0][CNT_W-1:0]     cnt_w, match_w;
   logic [NCH-1:0][CTRL_FULL-1:0] ctrl_w;
   logic [NCH-1:0][SEL_W-1:0]     sel_w;
   logic [NCH-1:0]                adv_w, hit_w;
   logic [NCH-1:0]                en_w, stat_w;

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_ch
         localparam int LD = lead_of(k);
         mca_channel #(
            .CNT_W   (CNT_W),
            .CTRL_W  (ctrl_w_of(k)),
            .IS_LEAD (LD == k)
         ) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_en  (tick_en),
            .wr_match (wr_m[k]),
            .wr_cnt   (wr_c[k]),
            .wr_ctrl  (wr_t[k]),
            .wdata    (wr_data),
            .lead_cnt (cnt_w[LD]),
            .lead_adv (adv_w[LD]),
            .cnt_o    (cnt_w[k]),
            .adv_o    (adv_w[k]),
            .ctrl_o   (ctrl_w[k]),
            .match_o  (match_w[k]),
            .sel_o    (sel_w[k]),
            .hit_o    (hit_w[k])
         );
      end
   endgenerate

   mca_irq #(.N(NCH)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit_w),
      .wr_enable (wr_enab),
      .wr_status (wr_stat),
      .wbits     (wr_data[ST_OFS +: NCH]),
      .en_o      (en_w),
      .stat_o    (stat_w),
      .irq       (irq)
   );

   logic [DW-1:0] snap_q, rd_mux;
   logic          snap_take;

   assign snap_take = rd_en && (rd_rg == RG_COUNT) && (rd_k == 3'd5 || rd_k == 3'd7)
                      && ctrl_w[rd_k][CB_SNAP];

   always_comb begin
      rd_mux = '0;
      unique case (rd_rg)
         RG_MATCH: rd_mux = DW'(match_w[rd_k]);
         RG_COUNT: rd_mux = DW'(cnt_w[rd_k]);
         RG_CTRL:  rd_mux = DW'(ctrl_w[rd_k]);
         RG_MISC: begin
            if (rd_k == MX_STATUS)      rd_mux = DW'(stat_w) << ST_OFS;
            else if (rd_k == MX_ENABLE) rd_mux = DW'(en_w) << ST_OFS;
            else if (rd_k == MX_SNAP)   rd_mux = snap_q;
         end
         default: rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q  <= '0;
         rd_data <= '0;
      end else begin
         if (snap_take) snap_q <= DW'(cnt_w[rd_k - 3'd1]);
         if (rd_en)     rd_data <= rd_mux;
      end
   end
endmodule

// File: rtl/mca_chk.sv
module mca_chk import mca_pkg::*; #(
   parameter int CNT_W = 32
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      wr_en,
   input logic [4:0]                wr_addr,
   input logic                      rd_en,
   input logic                      irq,
   input logic [DW-1:0]             snap_q,
   input logic [NCH-1:0]            stat_w,
   input logic [NCH-1:0]            en_w,
   input logic [NCH-1:0]            hit_w,
   input logic [NCH-1:0][SEL_W-1:0] sel_w,
   input logic [NCH-1:0][CNT_W-1:0] cnt_w
);
   logic stat_wr;
   assign stat_wr = wr_en && (wr_addr == {RG_MISC, MX_STATUS});

   AST_IRQ_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(stat_wr)); // R11

   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !stat_wr) |=> irq); // R11

   AST_SNAP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(snap_q)); // R10

   generate
      for (genvar k = 0; k < NCH; k++) begin : g_ck
         AST_STATUS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat_w[k]) |-> $past(en_w[k])); // R4

         AST_STOPPED_COUNTER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (sel_w[k] == '0 && !hit_w[k] && !(wr_en && wr_addr == {RG_COUNT, 3'(k)}))
            |=> $stable(cnt_w[k])); // R2
      end
   endgenerate
endmodule

bind mca_array mca_chk #(.CNT_W(CNT_W)) u_mca_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .rd_en   (rd_en),
   .irq     (irq),
   .snap_q  (snap_q),
   .stat_w  (stat_w),
   .en_w    (en_w),
   .hit_w   (hit_w),
   .sel_w   (sel_w),
   .cnt_w   (cnt_w)
);

// File: tb/test_mca_array.sv
module test_mca_array;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  tick_en = '0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rd_en = 1'b0;
   logic [4:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   mca_array i_mca_array (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
   );

   // address helpers (index = channel - 4)
   function automatic logic [4:0] AM(input int k); return 5'(k);      endfunction
   function automatic logic [4:0] AC(input int k); return 5'(8 + k);  endfunction
   function automatic logic [4:0] AT(input int k); return 5'(16 + k); endfunction
   localparam logic [4:0] A_ST = 5'd24, A_EN = 5'd25, A_SN = 5'd26;

   typedef struct packed {
      logic [1:0]  op;   // 0 write, 1 read+compare, 2 run ticks
      logic [4:0]  a;
      logic [31:0] d;
      logic [7:0]  m;
      logic [7:0]  r;
   } vec_t;

   function automatic vec_t VW(input logic [4:0] a, input logic [31:0] d);
      return '{op: 2'd0, a: a, d: d, m: 8'h0, r: 8'd0};
   endfunction
   function automatic vec_t VR(input logic [4:0] a, input logic [31:0] d, input int r);
      return '{op: 2'd1, a: a, d: d, m: 8'h0, r: 8'(r)};
   endfunction
   function automatic vec_t VT(input int n, input logic [7:0] m);
      return '{op: 2'd2, a: 5'd0, d: 32'(n), m: m, r: 8'd0};
   endfunction

   localparam int NV = 63;
   localparam vec_t VECS [NV] = '{
      VW(AT(0), 32'h01),          // ch4 lead, sel 1
      VT(5, 8'h02),
      VR(AC(0), 32'd5, 2),        // R2 five ticks
      VT(3, 8'h04),
      VR(AC(0), 32'd5, 2),        // R2 other tick bit ignored
      VW(AT(1), 32'h3FF),
      VR(AT(1), 32'hFF, 7),       // R7 8-bit field
      VW(AT(4), 32'h3FF),
      VR(AT(4), 32'h3FF, 7),      // R7 10-bit field
      VT(2, 8'h80),
      VR(AC(1), 32'd2, 2),        // R2 sel 7
      VR(AC(4), 32'd0, 9),        // R9 forced stop
      VW(AT(1), 32'h00),
      VW(AT(4), 32'h00),
      VT(1, 8'h80),
      VR(AC(1), 32'd3, 8),        // R8 selection kept
      VW(A_EN, 32'h010),
      VW(AM(0), 32'd8),
      VT(3, 8'h02),
      VR(A_ST, 32'h010, 4),       // R4 match sets bit 4
      VW(A_ST, 32'h010),
      VW(AT(0), 32'h09),
      VW(AM(0), 32'd3),
      VW(AC(0), 32'd0),
      VT(3, 8'h02),
      VR(AC(0), 32'd0, 5),        // R5 cleared on match
      VR(A_ST, 32'h010, 5),       // R5
      VW(A_ST, 32'h010),
      VT(3, 8'h02),
      VR(AC(0), 32'd3, 6),        // R6 one-shot: no second match
      VR(A_ST, 32'h000, 6),       // R6
      VW(AT(0), 32'h49),
      VW(AC(0), 32'd0),
      VW(AM(0), 32'd3),
      VT(6, 8'h02),
      VR(AC(0), 32'd0, 6),        // R6 periodic: two matches
      VR(A_ST, 32'h010, 6),       // R6
      VW(A_ST, 32'hFF0),
      VW(AT(0), 32'h01),
      VW(AC(0), 32'd0),
      VW(A_EN, 32'h020),
      VW(AT(1), 32'h00),
      VW(AM(1), 32'd4),
      VT(4, 8'h02),
      VR(A_ST, 32'h020, 3),       // R3 group counter, ch4 not enabled (R4)
      VR(AC(1), 32'd3, 3),        // R3 own counter untouched
      VW(A_ST, 32'h020),
      VW(AT(1), 32'h87),
      VW(AC(1), 32'd0),
      VW(AM(1), 32'd2),
      VT(2, 8'h02),
      VR(A_ST, 32'h000, 3),       // R3 leader ticks ignored
      VT(2, 8'h80),
      VR(A_ST, 32'h020, 3),       // R3 own counter matches
      VW(AT(4), 32'h081),
      VW(AC(4), 32'h1234),
      VW(AT(5), 32'h200),
      VR(AC(5), 32'd0, 10),       // R10 own counter returned
      VR(A_SN, 32'h1234, 10),     // R10 snapshot taken
      VW(AT(5), 32'h000),
      VW(AC(4), 32'h55),
      VR(AC(5), 32'd0, 10),
      VR(A_SN, 32'h1234, 10)      // R10 snapshot held
   };

   task automatic check(input bit ok, input int r, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL R%0d actual=0x%08h expected=0x%08h", r, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic run(input int n, input logic [7:0] m);
      @(negedge clk);
      tick_en = m;
      repeat (n) @(negedge clk);
      tick_en = '0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check(irq == 1'b0, 1, 32'(irq), 32'd0);
      check(rd_data == 32'd0, 1, rd_data, 32'd0);
      rd(A_ST, v);  check(v == 32'd0, 1, v, 32'd0);
      rd(AT(6), v); check(v == 32'd0, 1, v, 32'd0);
      rd(AC(3), v); check(v == 32'd0, 1, v, 32'd0);
      rd(A_SN, v);  check(v == 32'd0, 1, v, 32'd0);

      for (int i = 0; i < NV; i++) begin
         case (VECS[i].op)
            2'd0: wr(VECS[i].a, VECS[i].d);
            2'd1: begin
               rd(VECS[i].a, v);
               check(v == VECS[i].d, int'(VECS[i].r), v, VECS[i].d);
            end
            default: run(int'(VECS[i].d), VECS[i].m);
         endcase
      end

      // R12 rd_data holds between reads
      @(negedge clk);
      check(rd_data == 32'h1234, 12, rd_data, 32'h1234);

      // R11 shared interrupt across two channels
      wr(A_ST, 32'hFF0);
      wr(A_EN, 32'h050);
      wr(AT(0), 32'h01);
      wr(AC(0), 32'd0);
      wr(AM(0), 32'd2);
      wr(AT(2), 32'h00);
      wr(AM(2), 32'd3);
      check(irq == 1'b0, 11, 32'(irq), 32'd0);
      run(2, 8'h02);
      check(irq == 1'b1, 11, 32'(irq), 32'd1);
      run(1, 8'h02);
      rd(A_ST, v);
      check(v == 32'h050, 11, v, 32'h050);
      wr(A_ST, 32'h010);
      check(irq == 1'b1, 11, 32'(irq), 32'd1);
      wr(A_ST, 32'h040);
      check(irq == 1'b0, 11, 32'(irq), 32'd0);
      rd(A_EN, v);
      check(v == 32'h050, 12, v, 32'h050);

      finish_up();
   end
endmodule